// File: doc/BRIEF.md
# Four-Instruction Stored-Program Core

This block is a small multicycle processor. It fetches 32-bit instructions from one shared, byte-addressed word memory and carries out four of them: register add, register subtract, load word and store word. Program and data sit in the same memory and use the same single synchronous port. Each instruction moves through a fixed sequence of steps: fetch, decode into an instruction register, execute, memory access when needed, and register write. The only state is a program counter, the instruction register, a result latch and a 32 x 32-bit register file.

The core has no branches, so it runs a program in a straight line. Any word it does not recognise is a three-cycle no-op, and the program counter still moves on. Software reaches the registers only through store instructions.

Top module: `quad_op_cpu`

## Requirements
- R1: While reset is asserted and in the first cycle after release, the core drives address 0 with `mem_we` low. Execution starts from byte address 0.
- R2: The program counter advances by exactly 4 once per instruction, at the end of its fetch cycle, and stays put in every other cycle.
- R3: A word with bits[31:26]=0 and bits[5:0]=32 writes the register named by bits[15:11] with the wrapped 32-bit sum of the registers named by bits[25:21] and bits[20:16].
- R4: A word with bits[31:26]=0 and bits[5:0]=34 writes the register named by bits[15:11] with the wrapped 32-bit difference: register bits[25:21] minus register bits[20:16].
- R5: A word with bits[31:26]=35 loads the register named by bits[20:16] from memory at (register bits[25:21]) + sign-extended bits[15:0].
- R6: A word with bits[31:26]=43 writes the register named by bits[20:16] to memory at (register bits[25:21]) + sign-extended bits[15:0]. It is the only instruction that raises `mem_we`.
- R7: Register 0 always reads as zero, and any write to it is dropped.
- R8: Any other opcode or function code changes no register and no memory. It takes 3 cycles, and the next instruction is fetched from the following word.
- R9: Add, subtract and store take 4 cycles and load takes 5. A store raises `mem_we` in its fourth cycle.
- R10: `mem_addr` always has its two low bits at 0, so an effective address is truncated to its word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 32 | Byte address of the word being read or written |
| mem_wdata | output | 32 | Data to be written when `mem_we` is high |
| mem_we | output | 1 | Write strobe for the memory word at `mem_addr` |
| mem_rdata | input | 32 | Word read from the address presented in the previous cycle |

## Verification
The assertions assume that the memory returns the word for an address exactly one cycle after that address is presented, and that reset is held across at least one rising edge. The bench's memory model behaves this way. Each program is straight-line code placed at low addresses, with its data at byte 1024 and above, so fetches and data accesses never overlap. Every register is loaded before it is read, so no undefined register-file entry can reach a checked result.

// File: rtl/quad_op_cpu.sv
module quad_op_cpu #(
  parameter logic [31:0] RESET_PC = 32'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  input  logic [31:0] mem_rdata
);
  localparam logic [5:0] OP_ALU = 6'd0;
  localparam logic [5:0] OP_LW  = 6'd35;
  localparam logic [5:0] OP_SW  = 6'd43;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;

  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_EXEC, S_MEM, S_WB} step_t;

  step_t       st;
  logic [31:0] pc, ir, res;
  logic [31:0] rf [32];

  wire [5:0]  op    = ir[31:26];
  wire [4:0]  rs    = ir[25:21];
  wire [4:0]  rt    = ir[20:16];
  wire [4:0]  rd    = ir[15:11];
  wire [5:0]  funct = ir[5:0];
  wire        is_rr = (op == OP_ALU) && (funct == FN_ADD || funct == FN_SUB);
  wire        is_lw = (op == OP_LW);
  wire        is_sw = (op == OP_SW);
  wire [31:0] va    = (rs == 5'd0) ? 32'd0 : rf[rs];
  wire [31:0] vb    = (rt == 5'd0) ? 32'd0 : rf[rt];
  wire [31:0] sext  = {{16{ir[15]}}, ir[15:0]};
  wire [4:0]  dst   = is_lw ? rt : rd;
  wire [31:0] wval  = is_lw ? mem_rdata : res;

  assign mem_addr  = {(st == S_MEM) ? res[31:2] : pc[31:2], 2'b00};
  assign mem_we    = (st == S_MEM) && is_sw;
  assign mem_wdata = vb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_FETCH;
      pc  <= RESET_PC;
      ir  <= 32'd0;
      res <= 32'd0;
    end else begin
      case (st)
        S_FETCH: begin
          pc <= pc + 32'd4;
          st <= S_DECODE;
        end
        S_DECODE: begin
          ir <= mem_rdata;
          st <= S_EXEC;
        end
        S_EXEC: begin
          if (is_lw || is_sw) begin
            res <= va + sext;
            st  <= S_MEM;
          end else if (is_rr) begin
            res <= (funct == FN_SUB) ? va - vb : va + vb;
            st  <= S_WB;
          end else begin
            st <= S_FETCH;
          end
        end
        S_MEM:   st <= is_lw ? S_WB : S_FETCH;
        default: st <= S_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && st == S_WB && dst != 5'd0)
      rf[dst] <= wval;
  end

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH) |=> (pc == $past(pc) + 32'd4));
  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_FETCH) |=> $stable(pc));
  assert_lw_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MEM && is_lw) |=> (st == S_WB));
  assert_ir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_DECODE) |=> $stable(ir));
  assert_nop_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EXEC && !is_rr && !is_lw && !is_sw) |=> (st == S_FETCH));
  assert_wb_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB) |-> (is_lw || is_rr));
endmodule

// File: tb/quad_op_cpu_test.sv
module quad_op_cpu_test;
  localparam int CLK_PERIOD = 10;
  localparam int MWORDS = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic [31:0] mem [MWORDS];

  int n_tests = 0;
  int n_fail = 0;
  int cyc;
  int nwr;
  int wcyc [4];

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[10:2]];
  end

  quad_op_cpu uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] enc_r(input int s, input int t, input int d, input int fn);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(input int op, input int s, input int t, input int imm);
    return {6'(op), 5'(s), 5'(t), 16'(imm)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MWORDS; i++) mem[i] = 32'd0;
  endtask

  task automatic run_prog(input int ncyc);
    nwr = 0;
    for (int i = 0; i < 4; i++) wcyc[i] = -1;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (cyc = 0; cyc < ncyc; cyc++) begin
      if (mem_we) begin
        if (nwr < 4) wcyc[nwr] = cyc;
        nwr++;
      end
      @(negedge clk);
    end
  endtask

  logic [31:0] vals [6] = '{32'd0, 32'd1, 32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff, 32'h1234_5678};

  initial begin
    // R1: reset state and first fetch address
    repeat (2) @(negedge clk);
    check(mem_addr == 32'd0, "R1 reset addr", mem_addr, 32'd0);
    check(mem_we == 1'b0, "R1 reset we", {31'd0, mem_we}, 32'd0);

    // R3 R4 R5 R6 R9: operand sweep for add and sub
    foreach (vals[i]) foreach (vals[j]) begin
      clear_mem();
      mem[0] = enc_i(35, 0, 1, 1200);
      mem[1] = enc_i(35, 0, 2, 1204);
      mem[2] = enc_r(1, 2, 3, 32);
      mem[3] = enc_r(1, 2, 4, 34);
      mem[4] = enc_i(43, 0, 3, 1208);
      mem[5] = enc_i(43, 0, 4, 1212);
      mem[300] = vals[i];
      mem[301] = vals[j];
      run_prog(40);
      check(mem[302] == vals[i] + vals[j], "R3 add", mem[302], vals[i] + vals[j]);
      check(mem[303] == vals[i] - vals[j], "R4 sub", mem[303], vals[i] - vals[j]);
      check(wcyc[0] == 21 && wcyc[1] == 25, "R9 store cycles", 32'(wcyc[0]), 32'd21);
      check(nwr == 2, "R6 write count", 32'(nwr), 32'd2);
    end

    // R5 R6 R10: base register, negative offset, unaligned base
    clear_mem();
    mem[0] = enc_i(35, 0, 9, 1024);
    mem[1] = enc_i(35, 9, 8, -102);
    mem[2] = enc_i(35, 0, 18, 1028);
    mem[3] = enc_r(18, 8, 8, 32);
    mem[4] = enc_i(43, 9, 8, -102);
    mem[256] = 32'd1302;
    mem[257] = 32'd77;
    mem[300] = 32'd1000;
    run_prog(40);
    check(mem[300] == 32'd1077, "R5 R6 R10 signed offset", mem[300], 32'd1077);
    check(wcyc[0] == 22, "R9 lw then store timing", 32'(wcyc[0]), 32'd22);

    // R7: register zero
    clear_mem();
    mem[0] = enc_i(35, 0, 0, 1024);
    mem[1] = enc_i(35, 0, 5, 1024);
    mem[2] = enc_r(5, 5, 0, 32);
    mem[3] = enc_i(43, 0, 0, 1216);
    mem[4] = enc_r(0, 5, 6, 32);
    mem[5] = enc_i(43, 0, 6, 1220);
    mem[256] = 32'h55;
    mem[304] = 32'hdead;
    run_prog(45);
    check(mem[304] == 32'd0, "R7 r0 reads zero", mem[304], 32'd0);
    check(mem[305] == 32'h55, "R7 r0 operand zero", mem[305], 32'h55);

    // R8 R9: unrecognised words are three-cycle no-ops
    clear_mem();
    mem[0] = enc_i(35, 0, 1, 1200);
    mem[1] = enc_i(8, 1, 1, 5);
    mem[2] = enc_r(1, 1, 1, 33);
    mem[3] = 32'hffff_ffff;
    mem[4] = enc_i(43, 0, 1, 1204);
    mem[300] = 32'hcafe_0001;
    run_prog(30);
    check(mem[301] == 32'hcafe_0001, "R8 nop leaves rt/rd", mem[301], 32'hcafe_0001);
    check(wcyc[0] == 17, "R8 nop length", 32'(wcyc[0]), 32'd17);
    check(nwr == 1, "R8 no stray write", 32'(nwr), 32'd1);

    // R2 R10: fetch address after one load
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(mem_addr == 32'd4, "R2 second fetch", mem_addr, 32'd4);
    check(mem_addr[1:0] == 2'b00, "R10 aligned", mem_addr, {mem_addr[31:2], 2'b00});

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule